// File: doc/BRIEF.md
# Wireless Device Bring-Up Sequencer

This block sits on the host side of a SPI link to a wireless device. After the host comes out of reset it takes the device from power-on to a usable state without software help. It drives register reads and writes through a plain command port (valid, write flag, function number, address, write data, done pulse, read data). A SPI master outside this block turns those commands into bus transfers.

The sequence runs in five phases:

1. **Power-up wait.** The sequencer waits a power-up time, set by the clock frequency and a delay in milliseconds.
2. **Signature poll.** It reads a signature register again and again until the expected word comes back.
3. **Wake-up.** It reads the configuration word, then writes it back with the wake-up bit set.
4. **Low-power clock and crystal code.** It waits for the device's low-power clock to report available, then writes the crystal-frequency code into a power-management register. That write lets the device PLL lock.
5. **Chip-active wait.** It waits for the chip-active interrupt.

It then raises `ready`. If a poll or a wait runs past its limit, it raises `error` instead. Either final flag holds until the next reset.

The signature value, the power-management function and address, the crystal code, the wake-up bit position and every limit are parameters.

Top module: `wlan_boot_seq`

## Requirements
- R1: While reset is applied and directly after it, `ready`, `error` and `cmd_valid` are all low.
- R2: No command is issued before DELAY_CYC = (CLK_HZ/1000)*DELAY_MS clock cycles have passed after reset release. The first signature read starts in exactly that cycle.
- R3: The signature poll is a read (`cmd_write`=0) of function 0, address SIG_ADDR (default 0x14). After each mismatching read, `cmd_valid` stays low for SIG_GAP_CYC cycles before the next read. The poll ends at the first read whose data equals SIG_VALUE.
- R4: When SIG_TRIES consecutive signature reads all mismatch, the sequencer enters the error state and issues no further command.
- R5: After a signature match, the sequencer reads function 0 address 0 and then writes function 0 address 0. The write data equals the read word with bit WAKE_BIT (default 7) set and every other bit unchanged.
- R6: `lpclk_avail` is only acted on after the wake-up write. The power-management write follows only once `lpclk_avail` is seen high. If it stays low for LPCLK_WAIT_CYC cycles, the sequencer enters the error state without writing.
- R7: The power-management write uses function PMU_FUNC, address PMU_ADDR and data XTAL_CODE. It is the last write of the sequence.
- R8: `chip_active` only matters after the power-management write has completed. If it is high earlier, that has no effect. `ready` rises only after `chip_active` is seen high in the wait. If it stays low for IRQ_WAIT_CYC cycles, the error state is entered.
- R9: `ready` and `error` are never high together. Each one, once high, holds (with `cmd_valid` low in error) until reset.
- R10: A command keeps `cmd_valid`, `cmd_write`, `cmd_func`, `cmd_addr` and `cmd_wdata` steady until the cycle in which `cmd_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| cmd_valid | output | 1 | Command request to the SPI master |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_func | output | 2 | Device function number |
| cmd_addr | output | ADDR_W | Register address |
| cmd_wdata | output | DATA_W | Write data |
| cmd_done | input | 1 | One-cycle completion pulse from the SPI master |
| cmd_rdata | input | DATA_W | Read data, valid with cmd_done |
| lpclk_avail | input | 1 | Device low-power clock available (level) |
| chip_active | input | 1 | Chip-active interrupt (level) |
| ready | output | 1 | Device brought up |
| error | output | 1 | Bring-up failed on timeout |

## Verification
The bench shrinks the timing parameters so that whole bring-ups fit in a short run:

| Parameter | Bench value |
|---|---|
| CLK_HZ | 10 000 |
| DELAY_MS | 2 (so the power-up wait is 20 cycles) |
| SIG_TRIES | 4 |
| SIG_GAP_CYC | 3 |
| LPCLK_WAIT_CYC | 30 |
| IRQ_WAIT_CYC | 40 |

It also chooses a non-default power-management function and address, and a configuration word whose wake-up bit starts clear. With these values the exact power-up cycle and the poll gap can be measured. The signature, low-power clock and chip-active timeouts can each be reached, and the read-modify-write is visible bit for bit.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   typedef enum logic [3:0] {
      ST_PWR_WAIT = 4'd0,
      ST_SIG_RD   = 4'd1,
      ST_SIG_GAP  = 4'd2,
      ST_CFG_RD   = 4'd3,
      ST_CFG_WR   = 4'd4,
      ST_LP_WAIT  = 4'd5,
      ST_PMU_WR   = 4'd6,
      ST_IRQ_WAIT = 4'd7,
      ST_READY    = 4'd8,
      ST_FAIL     = 4'd9
   } boot_state_t;

   localparam logic [1:0] FUNC_BUS = 2'd0;

endpackage

// File: rtl/boot_counter.sv
module boot_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   generate
      if (W < 1) begin : g_bad_w
         $error("boot_counter: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/boot_cmd_gen.sv
module boot_cmd_gen
   import boot_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 17,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned SIG_ADDR  = 32'h14,
   parameter int unsigned CFG_ADDR  = 32'h0,
   parameter int unsigned PMU_FUNC  = 1,
   parameter int unsigned PMU_ADDR  = 32'h1_0000,
   parameter logic [DATA_W-1:0] XTAL_CODE = '0,
   parameter int unsigned WAKE_BIT  = 7
) (
   input  boot_state_t       state,
   input  logic [DATA_W-1:0] cfg_word,
   output logic              valid,
   output logic              write,
   output logic [1:0]        func,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);
   localparam logic [DATA_W-1:0] WAKE_MASK = DATA_W'(1) << WAKE_BIT;

   generate
      if (WAKE_BIT >= DATA_W) begin : g_bad_wake
         $error("boot_cmd_gen: WAKE_BIT outside data word");
      end
      if (PMU_FUNC > 3) begin : g_bad_func
         $error("boot_cmd_gen: PMU_FUNC needs more than 2 bits");
      end
   endgenerate

   always_comb begin
      valid = 1'b0;
      write = 1'b0;
      func  = FUNC_BUS;
      addr  = '0;
      wdata = '0;
      case (state)
         ST_SIG_RD: begin
            valid = 1'b1;
            addr  = ADDR_W'(SIG_ADDR);
         end
         ST_CFG_RD: begin
            valid = 1'b1;
            addr  = ADDR_W'(CFG_ADDR);
         end
         ST_CFG_WR: begin
            valid = 1'b1;
            write = 1'b1;
            addr  = ADDR_W'(CFG_ADDR);
            wdata = cfg_word | WAKE_MASK;
         end
         ST_PMU_WR: begin
            valid = 1'b1;
            write = 1'b1;
            func  = 2'(PMU_FUNC);
            addr  = ADDR_W'(PMU_ADDR);
            wdata = XTAL_CODE;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/wlan_boot_seq.sv
module wlan_boot_seq
   import boot_seq_pkg::*;
#(
   parameter int unsigned ADDR_W         = 17,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned CLK_HZ         = 125_000_000,
   parameter int unsigned DELAY_MS       = 50,
   parameter logic [DATA_W-1:0] SIG_VALUE = 32'hFEED_BEAD,
   parameter int unsigned SIG_ADDR       = 32'h14,
   parameter int unsigned SIG_TRIES      = 64,
   parameter int unsigned SIG_GAP_CYC    = 1000,
   parameter int unsigned WAKE_BIT       = 7,
   parameter int unsigned PMU_FUNC       = 1,
   parameter int unsigned PMU_ADDR       = 32'h1_0000,
   parameter logic [DATA_W-1:0] XTAL_CODE = 32'h0000_0064,
   parameter int unsigned LPCLK_WAIT_CYC = 1_250_000,
   parameter int unsigned IRQ_WAIT_CYC   = 1_250_000
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cmd_valid,
   output logic              cmd_write,
   output logic [1:0]        cmd_func,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_wdata,
   input  logic              cmd_done,
   input  logic [DATA_W-1:0] cmd_rdata,
   input  logic              lpclk_avail,
   input  logic              chip_active,
   output logic              ready,
   output logic              error
);
   localparam int unsigned DELAY_CYC = (CLK_HZ / 1000) * DELAY_MS;
   localparam int unsigned MAX_AB    = (DELAY_CYC > SIG_GAP_CYC) ? DELAY_CYC : SIG_GAP_CYC;
   localparam int unsigned MAX_CD    = (LPCLK_WAIT_CYC > IRQ_WAIT_CYC) ? LPCLK_WAIT_CYC : IRQ_WAIT_CYC;
   localparam int unsigned CYC_MAX   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int unsigned CW        = $clog2(CYC_MAX + 1);
   localparam int unsigned RW        = $clog2(SIG_TRIES + 1);

   generate
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("wlan_boot_seq: power-up delay rounds to zero cycles");
      end
      if (SIG_TRIES < 1) begin : g_bad_tries
         $error("wlan_boot_seq: SIG_TRIES must be at least 1");
      end
      if (LPCLK_WAIT_CYC < 1 || IRQ_WAIT_CYC < 1) begin : g_bad_wait
         $error("wlan_boot_seq: wait limits must be at least 1");
      end
      if (ADDR_W < 8 || DATA_W < 8) begin : g_bad_width
         $error("wlan_boot_seq: address and data need at least 8 bits");
      end
   endgenerate

   boot_state_t       state_q, state_nx;
   logic [CW-1:0]     cyc_cnt;
   logic [RW-1:0]     try_cnt;
   logic [DATA_W-1:0] cfg_q;
   logic              sig_hit, sig_miss, gap_over;

   assign sig_hit  = (state_q == ST_SIG_RD) && cmd_done && (cmd_rdata == SIG_VALUE);
   assign sig_miss = (state_q == ST_SIG_RD) && cmd_done && (cmd_rdata != SIG_VALUE);

   boot_counter #(.W(CW)) u_cyc_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_nx != state_q),
      .inc   ((state_q != ST_READY) && (state_q != ST_FAIL)),
      .cnt   (cyc_cnt)
   );

   boot_counter #(.W(RW)) u_try_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q == ST_PWR_WAIT),
      .inc   (sig_miss),
      .cnt   (try_cnt)
   );

   generate
      if (SIG_GAP_CYC == 0) begin : g_no_gap
         assign gap_over = 1'b1;
      end else begin : g_gap
         assign gap_over = (cyc_cnt == CW'(SIG_GAP_CYC - 1));
      end
   endgenerate

   always_comb begin
      state_nx = state_q;
      case (state_q)
         ST_PWR_WAIT:
            if (cyc_cnt == CW'(DELAY_CYC - 1)) state_nx = ST_SIG_RD;
         ST_SIG_RD:
            if (sig_hit) state_nx = ST_CFG_RD;
            else if (sig_miss)
               state_nx = (try_cnt == RW'(SIG_TRIES - 1)) ? ST_FAIL : ST_SIG_GAP;
         ST_SIG_GAP:
            if (gap_over) state_nx = ST_SIG_RD;
         ST_CFG_RD:
            if (cmd_done) state_nx = ST_CFG_WR;
         ST_CFG_WR:
            if (cmd_done) state_nx = ST_LP_WAIT;
         ST_LP_WAIT:
            if (lpclk_avail) state_nx = ST_PMU_WR;
            else if (cyc_cnt == CW'(LPCLK_WAIT_CYC - 1)) state_nx = ST_FAIL;
         ST_PMU_WR:
            if (cmd_done) state_nx = ST_IRQ_WAIT;
         ST_IRQ_WAIT:
            if (chip_active) state_nx = ST_READY;
            else if (cyc_cnt == CW'(IRQ_WAIT_CYC - 1)) state_nx = ST_FAIL;
         ST_READY: state_nx = ST_READY;
         default:  state_nx = ST_FAIL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_PWR_WAIT;
         cfg_q   <= '0;
      end else begin
         state_q <= state_nx;
         if ((state_q == ST_CFG_RD) && cmd_done) cfg_q <= cmd_rdata;
      end
   end

   boot_cmd_gen #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SIG_ADDR  (SIG_ADDR),
      .CFG_ADDR  (0),
      .PMU_FUNC  (PMU_FUNC),
      .PMU_ADDR  (PMU_ADDR),
      .XTAL_CODE (XTAL_CODE),
      .WAKE_BIT  (WAKE_BIT)
   ) u_cmd_gen (
      .state    (state_q),
      .cfg_word (cfg_q),
      .valid    (cmd_valid),
      .write    (cmd_write),
      .func     (cmd_func),
      .addr     (cmd_addr),
      .wdata    (cmd_wdata)
   );

   assign ready = (state_q == ST_READY);
   assign error = (state_q == ST_FAIL);
endmodule

// File: rtl/wlan_boot_seq_chk.sv
module wlan_boot_seq_chk #(
   parameter int unsigned ADDR_W    = 17,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DELAY_CYC = 1,
   parameter int unsigned WAKE_BIT  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_write,
   input logic [1:0]        cmd_func,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [DATA_W-1:0] cmd_wdata,
   input logic              cmd_done,
   input logic              chip_active,
   input logic              ready,
   input logic              error
);
   logic [31:0] since_rst;

   always_ff @(posedge clk) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst < DELAY_CYC) since_rst <= since_rst + 1;
   end

   AST_NO_EARLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (since_rst >= DELAY_CYC)); // R2
   AST_WAKE_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write && cmd_func == 2'd0 && cmd_addr == '0) |-> cmd_wdata[WAKE_BIT]); // R5
   AST_READY_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(chip_active)); // R8
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && error)); // R9
   AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready); // R9
   AST_ERROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> (error && !cmd_valid)); // R9
   AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_write) && $stable(cmd_func)
                                    && $stable(cmd_addr) && $stable(cmd_wdata))); // R10
endmodule

bind wlan_boot_seq wlan_boot_seq_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .DELAY_CYC (DELAY_CYC),
   .WAKE_BIT  (WAKE_BIT)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_write   (cmd_write),
   .cmd_func    (cmd_func),
   .cmd_addr    (cmd_addr),
   .cmd_wdata   (cmd_wdata),
   .cmd_done    (cmd_done),
   .chip_active (chip_active),
   .ready       (ready),
   .error       (error)
);

// File: tb/wlan_boot_seq_tb_top.sv
module wlan_boot_seq_tb_top;
   localparam int unsigned ADDR_W = 17;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned DELAY  = 20;          // 10000/1000*2
   localparam int unsigned TRIES  = 4;
   localparam int unsigned GAP    = 3;
   localparam logic [31:0] SIG    = 32'hFEED_BEAD;
   localparam logic [31:0] XTAL   = 32'h0000_0A5C;
   localparam int unsigned PFUNC  = 2;
   localparam int unsigned PADDR  = 17'h1_0A20;
   localparam logic [31:0] CFG0   = 32'h00A5_0033;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid, cmd_write;
   logic [1:0]        cmd_func;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_wdata;
   logic              cmd_done = 1'b0;
   logic [DATA_W-1:0] cmd_rdata = '0;
   logic              lpclk_avail = 1'b0;
   logic              chip_active = 1'b0;
   logic              ready, error;

   always #4 clk = ~clk;

   wlan_boot_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_HZ(10_000), .DELAY_MS(2),
      .SIG_VALUE(SIG), .SIG_ADDR(32'h14), .SIG_TRIES(TRIES), .SIG_GAP_CYC(GAP),
      .WAKE_BIT(7), .PMU_FUNC(PFUNC), .PMU_ADDR(PADDR), .XTAL_CODE(XTAL),
      .LPCLK_WAIT_CYC(30), .IRQ_WAIT_CYC(40)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_func(cmd_func), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .lpclk_avail(lpclk_avail),
      .chip_active(chip_active), .ready(ready), .error(error)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // device model state
   int          bad_sigs, sig_reads, lat, low_run, prev_gap, gap_obs;
   int          wr_count, wake_at, pmu_at, other_rd;
   int          lp_mode, lp_delay, lp_cnt, irq_mode, irq_delay, irq_cnt;
   bit          wake_seen, pmu_seen, rdy_before_pmu, rdy_before_irq, cmd_in_err;
   logic [31:0] reg0, wake_data, pmu_data;
   logic [1:0]  pmu_func;
   logic [16:0] pmu_addr;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic start(input int bad, input int lpm, input int lpd, input int irm, input int ird);
      rst_n = 1'b0;
      bad_sigs = bad; lp_mode = lpm; lp_delay = lpd; irq_mode = irm; irq_delay = ird;
      sig_reads = 0; lat = 0; low_run = 0; prev_gap = 0; gap_obs = -1;
      wr_count = 0; wake_at = -1; pmu_at = -1; other_rd = 0;
      lp_cnt = 0; irq_cnt = 0; wake_seen = 0; pmu_seen = 0;
      rdy_before_pmu = 0; rdy_before_irq = 0; cmd_in_err = 0;
      reg0 = CFG0; wake_data = '0; pmu_data = '0; pmu_func = '0; pmu_addr = '0;
      cmd_done = 1'b0;
      lpclk_avail = (lpm == 2);
      chip_active = (irm == 2);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_end(input int limit);
      for (int i = 0; i < limit && !ready && !error; i++) @(negedge clk);
   endtask

   // responder: SPI master plus device model, driven at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         cmd_done = 1'b0;
         if (rst_n) begin
            if (ready && !pmu_seen) rdy_before_pmu = 1;
            if (ready && !chip_active) rdy_before_irq = 1;
            if (error && cmd_valid) cmd_in_err = 1;
            if (cmd_valid) begin
               if (low_run > 0) prev_gap = low_run;
               low_run = 0;
               lat++;
               if (lat == 2) begin
                  lat = 0;
                  cmd_done = 1'b1;
                  if (cmd_write) begin
                     wr_count++;
                     if (cmd_func == 2'd0 && cmd_addr == '0) begin
                        wake_seen = 1; wake_at = wr_count; wake_data = cmd_wdata; reg0 = cmd_wdata;
                     end else begin
                        pmu_seen = 1; pmu_at = wr_count; pmu_data = cmd_wdata;
                        pmu_func = cmd_func; pmu_addr = cmd_addr;
                     end
                  end else if (cmd_func == 2'd0 && cmd_addr == 17'h14) begin
                     sig_reads++;
                     if (sig_reads == 2) gap_obs = prev_gap;
                     cmd_rdata = (sig_reads > bad_sigs) ? SIG : (SIG ^ 32'h0000_0100);
                  end else if (cmd_func == 2'd0 && cmd_addr == '0) begin
                     cmd_rdata = reg0;
                  end else begin
                     other_rd++;
                     cmd_rdata = '0;
                  end
               end
            end else begin
               lat = 0;
               low_run++;
            end
            if (wake_seen && lp_mode == 1) begin
               lp_cnt++;
               if (lp_cnt >= lp_delay) lpclk_avail = 1'b1;
            end
            if (pmu_seen && irq_mode == 1) begin
               irq_cnt++;
               if (irq_cnt >= irq_delay) chip_active = 1'b1;
            end
         end
      end
   end

   task automatic t_reset_state;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(!ready && !error && !cmd_valid, "R1 flags in reset", {ready, error, cmd_valid}, 0);
      start(0, 1, 4, 1, 5);
      chk(!ready && !error && !cmd_valid, "R1 flags after release", {ready, error, cmd_valid}, 0);
   endtask

   task automatic t_normal_boot;
      int n;
      start(2, 1, 6, 1, 5);
      n = 0;
      while (!cmd_valid && n < 1000) begin @(negedge clk); n++; end
      chk(n == DELAY, "R2 cycles to first read", n, DELAY);
      chk(!cmd_write && cmd_func == 2'd0 && cmd_addr == 17'h14, "R3 poll command",
          {cmd_write, cmd_func, 12'h0, cmd_addr}, 32'h14);
      wait_end(500);
      chk(sig_reads == 3, "R3 reads until match", sig_reads, 3);
      chk(gap_obs == GAP, "R3 idle gap", gap_obs, GAP);
      chk(wake_data == (CFG0 | 32'h80), "R5 wake write data", wake_data, CFG0 | 32'h80);
      chk(pmu_data == XTAL && pmu_func == 2'(PFUNC) && pmu_addr == 17'(PADDR), "R7 pmu write",
          pmu_data, XTAL);
      chk(wr_count == 2 && pmu_at == 2 && wake_at == 1, "R7 write order", wr_count, 2);
      chk(ready && !error, "R8 ready reached", {ready, error}, 2'b10);
      chk(!rdy_before_irq, "R8 ready only after irq", rdy_before_irq, 0);
      repeat (30) @(negedge clk);
      chk(ready && !error && !cmd_valid, "R9 ready holds", {ready, error, cmd_valid}, 3'b100);
   endtask

   task automatic t_sig_timeout;
      start(100, 1, 4, 1, 5);
      wait_end(1000);
      chk(error && !ready, "R4 error on signature timeout", {ready, error}, 2'b01);
      chk(sig_reads == TRIES, "R4 number of tries", sig_reads, TRIES);
      chk(wr_count == 0, "R4 no write issued", wr_count, 0);
      repeat (40) @(negedge clk);
      chk(error && !cmd_in_err, "R9 error holds without commands", {error, cmd_in_err}, 2'b10);
   endtask

   task automatic t_lpclk_timeout;
      start(0, 0, 0, 2, 0);
      wait_end(1000);
      chk(error && !ready, "R6 error on lpclk timeout", {ready, error}, 2'b01);
      chk(wake_seen && !pmu_seen, "R6 no pmu write without lpclk", {wake_seen, pmu_seen}, 2'b10);
      chk(!rdy_before_pmu, "R8 early chip_active ignored", rdy_before_pmu, 0);
   endtask

   task automatic t_early_levels;
      start(0, 2, 0, 2, 0);
      wait_end(1000);
      chk(wake_at == 1 && pmu_at == 2, "R6 lpclk high early still waits for wake", pmu_at, 2);
      chk(!rdy_before_pmu, "R8 chip_active before pmu write ignored", rdy_before_pmu, 0);
      chk(ready && other_rd == 0, "R8 ready after early irq", {ready, 8'(other_rd)}, 9'h100);
   endtask

   task automatic t_irq_timeout;
      start(1, 1, 3, 0, 0);
      wait_end(1000);
      chk(error && !ready, "R8 error on irq timeout", {ready, error}, 2'b01);
      chk(pmu_seen, "R7 pmu write before irq wait", pmu_seen, 1);
      repeat (20) @(negedge clk);
      chk(error && !ready && !cmd_in_err, "R9 error sticky", {ready, error, cmd_in_err}, 3'b010);
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_normal_boot();
      t_sig_timeout();
      t_lpclk_timeout();
      t_early_levels();
      t_irq_timeout();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule